// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps the time of day and the calendar in BCD, from hundredths of a second up to a two-digit year. A working counter set advances on every pulse of a 100 Hz tick input. A second, host-visible register set mirrors it after every tick. Clearing a transfer-enable control bit freezes that visible set while the working counters keep running. The host can then read a coherent snapshot, or write new values that take effect when transfer is enabled again.

Hundredths advance on every tick. The carry into seconds and all higher fields is prepared while hundredths read 99 and applied on the tick that wraps hundredths to 00. The hours register has two encodings: 24-hour, or 12-hour with an AM/PM flag. Two control bits in the month register stop the oscillator and release the square-wave output. The square wave is derived from the block clock, which is assumed to run at 32,768 Hz, by a parameterised divider.

Top module: `rtc_dbl_clock`

## Requirements
- R1: After reset, every field reads zero except day-of-week, date and month, which read 0x01. The month register (index 9) reads 0xC1, because bit 7 (oscillator stop) and bit 6 (square-wave release) are both 1. The command register (index B) reads 0x80, so transfer is enabled.
- R2: While the oscillator runs, each tick advances hundredths (index 0) by one BCD step, and 0x99 wraps to 0x00.
- R3: Seconds through years change only on the tick that takes hundredths from 0x99 to 0x00, never on the tick that takes it to 0x99.
- R4: The calendar fields wrap as follows:
  - Seconds (index 1) and minutes (index 2) go from 0x59 to 0x00, and 24-hour hours (index 4) go from 0x23 to 0x00.
  - Day-of-week (index 6) counts 1 to 7 and goes from 7 back to 1 on every day change.
  - Date (index 8) returns to 0x01 after the last day of the month. April, June, September and November have 30 days, and February has 29 days when the year (index A) is divisible by 4 and 28 days otherwise.
  - Month goes from 0x12 to 0x01, and year goes from 0x99 to 0x00.
- R5: While command bit 7 is 1, a read returns the working count as of the most recent tick, and a host write to a time register loads both the working and the visible copy.
- R6: Writing command bit 7 as 0 holds every visible time register while the working count keeps advancing. Writing it as 1 makes the visible registers show the working count at once.
- R7: A time register written while the visible set is frozen reads back the written value immediately. That value is loaded into the working count when transfer is enabled again, and counting continues from it.
- R8: Hours bit 6 = 1 selects 12-hour mode, in which bit 5 = 1 means PM and bits 4:0 hold BCD 12, 01 to 11. The hour after 11 AM (0x51) is 12 PM (0x72). The hour after 11 PM (0x71) is 12 AM (0x52), and that transition also advances the date.
- R9: A write to hours whose bit 6 differs from the stored mode bit converts the current hour into the new encoding and discards the other written bits. For example, 11 AM becomes 0x51, and 11 PM becomes 0x23 when converted to 24-hour mode.
- R10: While month bit 7 is 1, ticks neither advance nor refresh any field, and host writes still take effect.
- R11: While month bit 6 is 0, sqw_drive is 1 and sqw_wave toggles every SQW_HALF clocks. While month bit 6 is 1, sqw_drive is 0, meaning the pad is released to high impedance. sqw_wave holds while the oscillator is stopped.
- R12: Unused bits read 0 and ignore writes:
  - bit 7 of seconds, minutes and hours;
  - bits 7:3 of day-of-week and bits 7:6 of date;
  - bit 5 of month and bits 6:0 of the command register.
  - Indices 3, 5, 7 and C to F read 0x00 in every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (32,768 Hz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_100hz | input | 1 | One-clock pulse every 10 ms |
| host_wr | input | 1 | Write strobe for the register port |
| host_addr | input | 4 | Register index for reads and writes |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from host_addr |
| sqw_wave | output | 1 | Square-wave level |
| sqw_drive | output | 1 | 1 = drive sqw_wave onto the pad, 0 = release (high impedance) |

## Verification
The stimulus preloads values at the edges of each counter: 59-second and 59-minute values, 23:00 and 11 AM/PM hours, and the last day of 28-, 29-, 30- and 31-day months. Each preload is followed by one tick to 99 and one tick past it. Comparing results after those two ticks separates a design that carries early from one that carries at the rollover. It also separates leap-year from ordinary February handling, and a 12-hour sequence with a correct AM/PM flip from one that flips on the wrong hour. Freeze sequences that include host writes and idle ticks show whether the hidden count kept running and whether the frozen writes were adopted on resume.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFLD = 8;
  typedef logic [NFLD-1:0][7:0] tod_t;

  localparam int F_HS   = 0;
  localparam int F_SEC  = 1;
  localparam int F_MIN  = 2;
  localparam int F_HR   = 3;
  localparam int F_DOW  = 4;
  localparam int F_DATE = 5;
  localparam int F_MON  = 6;
  localparam int F_YR   = 7;

  localparam logic [3:0] A_CMD = 4'hB;
  localparam logic [3:0] A_MON = 4'h9;

  function automatic logic [6:0] bcd2bin(logic [7:0] b);
    int v;
    v = int'(b[7:4]) * 10 + int'(b[3:0]);
    return 7'(v);
  endfunction

  function automatic logic [7:0] bin2bcd(logic [6:0] v);
    int t;
    int u;
    t = int'(v) / 10;
    u = int'(v) % 10;
    return {4'(t), 4'(u)};
  endfunction

  // hour register (either encoding) -> 0..23
  function automatic logic [6:0] hr_to_bin(logic [7:0] h);
    int h12;
    if (h[6]) begin
      h12 = int'(bcd2bin({3'b000, h[4:0]}));
      if (h12 == 12) h12 = 0;
      return 7'(h12 + (h[5] ? 12 : 0));
    end
    return bcd2bin({2'b00, h[5:0]});
  endfunction

  // 0..23 -> hour register in the requested encoding
  function automatic logic [7:0] hr_from_bin(logic [6:0] b, logic twelve);
    int v;
    logic pm;
    logic [7:0] t;
    v = int'(b);
    if (twelve) begin
      pm = (v >= 12);
      v = v % 12;
      if (v == 0) v = 12;
      t = bin2bcd(7'(v));
      return {2'b01, pm, t[4:0]};
    end
    t = bin2bcd(b);
    return {2'b00, t[5:0]};
  endfunction

  function automatic logic [6:0] days_in_month(logic [6:0] m, logic [6:0] y);
    case (m)
      7'd2:                      return (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

  function automatic logic [7:0] field_wmask(int f);
    case (f)
      F_SEC, F_MIN, F_HR: return 8'h7F;
      F_DOW:              return 8'h07;
      F_DATE:             return 8'h3F;
      F_MON:              return 8'h1F;
      default:            return 8'hFF;
    endcase
  endfunction

  // {valid, field index}
  function automatic logic [3:0] fld_of_addr(logic [3:0] a);
    case (a)
      4'h0: return {1'b1, 3'(F_HS)};
      4'h1: return {1'b1, 3'(F_SEC)};
      4'h2: return {1'b1, 3'(F_MIN)};
      4'h4: return {1'b1, 3'(F_HR)};
      4'h6: return {1'b1, 3'(F_DOW)};
      4'h8: return {1'b1, 3'(F_DATE)};
      4'h9: return {1'b1, 3'(F_MON)};
      4'hA: return {1'b1, 3'(F_YR)};
      default: return 4'h0;
    endcase
  endfunction

  function automatic tod_t tod_reset();
    tod_t t;
    t = '0;
    t[F_DOW]  = 8'h01;
    t[F_DATE] = 8'h01;
    t[F_MON]  = 8'h01;
    return t;
  endfunction
endpackage

// File: rtl/bcd_wrap_inc.sv
module bcd_wrap_inc #(
  parameter int MAXV = 59
) (
  input  logic [7:0] val,
  input  logic       en,
  output logic [7:0] nval,
  output logic       wrap
);
  import rtc_pkg::*;
  localparam logic [6:0] MAXB = 7'(MAXV);

  logic [6:0] bin;
  always_comb begin
    bin  = bcd2bin(val);
    wrap = en && (bin >= MAXB);
    if (!en)       nval = val;
    else if (wrap) nval = 8'h00;
    else           nval = bin2bcd(bin + 7'd1);
  end
endmodule

// File: rtl/rtc_carry_chain.sv
module rtc_carry_chain (
  input  rtc_pkg::tod_t cur,
  output rtc_pkg::tod_t nxt,
  output logic          sec_wrap,
  output logic          min_wrap,
  output logic          day_wrap,
  output logic          mon_wrap,
  output logic          yr_wrap
);
  import rtc_pkg::*;

  logic [7:0] sec_n, min_n, yr_n;
  logic [6:0] hr_b, date_b, mon_b, dim;
  logic       hr_wrap;

  bcd_wrap_inc #(.MAXV(59)) u_sec (.val(cur[F_SEC]), .en(1'b1),     .nval(sec_n), .wrap(sec_wrap));
  bcd_wrap_inc #(.MAXV(59)) u_min (.val(cur[F_MIN]), .en(sec_wrap), .nval(min_n), .wrap(min_wrap));
  bcd_wrap_inc #(.MAXV(99)) u_yr  (.val(cur[F_YR]),  .en(mon_wrap), .nval(yr_n),  .wrap(yr_wrap));

  always_comb begin
    hr_b    = hr_to_bin(cur[F_HR]);
    date_b  = bcd2bin(cur[F_DATE]);
    mon_b   = bcd2bin(cur[F_MON]);
    dim     = days_in_month(mon_b, bcd2bin(cur[F_YR]));
    hr_wrap = min_wrap && (hr_b >= 7'd23);
    day_wrap = hr_wrap && (date_b >= dim);
    mon_wrap = day_wrap && (mon_b >= 7'd12);

    nxt        = cur;
    nxt[F_SEC] = sec_n;
    nxt[F_MIN] = min_n;
    nxt[F_YR]  = yr_n;
    if (min_wrap)
      nxt[F_HR] = hr_from_bin(hr_wrap ? 7'd0 : hr_b + 7'd1, cur[F_HR][6]);
    if (hr_wrap) begin
      nxt[F_DOW]  = (cur[F_DOW] >= 8'h07 || cur[F_DOW] == 8'h00) ? 8'h01 : cur[F_DOW] + 8'h01;
      nxt[F_DATE] = day_wrap ? 8'h01 : bin2bcd(date_b + 7'd1);
    end
    if (day_wrap)
      nxt[F_MON] = mon_wrap ? 8'h01 : bin2bcd(mon_b + 7'd1);
  end
endmodule

// File: rtl/rtc_sqw_gen.sv
module rtc_sqw_gen #(
  parameter int HALF = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic wave
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (run_en) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        wave <= ~wave;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_dbl_clock.sv
module rtc_dbl_clock #(
  parameter int SQW_HALF = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_100hz,
  input  logic       host_wr,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       sqw_wave,
  output logic       sqw_drive
);
  import rtc_pkg::*;

  tod_t            int_q, vis_q, pend_q;
  tod_t            int_adv, int_d, vis_d, chain_nxt;
  logic [NFLD-1:0] dirty_q, dirty_d;
  logic            te_q, osc_off_q, sqw_off_q;

  // named events
  logic tick_run, hs_roll, resume_evt, cmd_wr, ctl_wr, time_wr, mode_conv;
  logic sec_wrap, min_wrap, day_wrap, mon_wrap, yr_wrap;
  logic [3:0] wdec;
  logic [2:0] wsel;
  logic [7:0] wval, src_hr;

  rtc_carry_chain u_chain (
    .cur(int_q), .nxt(chain_nxt),
    .sec_wrap(sec_wrap), .min_wrap(min_wrap), .day_wrap(day_wrap),
    .mon_wrap(mon_wrap), .yr_wrap(yr_wrap)
  );

  rtc_sqw_gen #(.HALF(SQW_HALF)) u_sqw (
    .clk(clk), .rst_n(rst_n), .run_en(~osc_off_q), .wave(sqw_wave)
  );
  assign sqw_drive = ~sqw_off_q;

  assign tick_run   = tick_100hz & ~osc_off_q;
  assign hs_roll    = tick_run && (int_q[F_HS] == 8'h99);
  assign wdec       = fld_of_addr(host_addr);
  assign wsel       = wdec[2:0];
  assign time_wr    = host_wr && wdec[3];
  assign cmd_wr     = host_wr && (host_addr == A_CMD);
  assign ctl_wr     = host_wr && (host_addr == A_MON);
  assign resume_evt = cmd_wr && host_wdata[7] && !te_q;
  assign src_hr     = te_q ? int_q[F_HR] : vis_q[F_HR];
  assign mode_conv  = time_wr && (int'(wsel) == F_HR) && (host_wdata[6] != src_hr[6]);

  always_comb begin
    if (mode_conv) wval = hr_from_bin(hr_to_bin(src_hr), host_wdata[6]);
    else           wval = host_wdata & field_wmask(int'(wsel));
  end

  // working count after this cycle's tick
  always_comb begin
    int_adv = int_q;
    if (hs_roll) begin
      int_adv       = pend_q;
      int_adv[F_HS] = 8'h00;
    end else if (tick_run) begin
      int_adv[F_HS] = bin2bcd(bcd2bin(int_q[F_HS]) + 7'd1);
    end
  end

  always_comb begin
    int_d   = int_adv;
    vis_d   = vis_q;
    dirty_d = dirty_q;
    if (te_q && tick_run) vis_d = int_adv;
    if (resume_evt) begin
      for (int f = 0; f < NFLD; f++) begin
        if (dirty_q[f]) int_d[f] = vis_q[f];
        else            vis_d[f] = int_adv[f];
      end
      dirty_d = '0;
    end
    if (time_wr) begin
      vis_d[wsel] = wval;
      if (te_q) int_d[wsel] = wval;
      else      dirty_d[wsel] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q     <= tod_reset();
      vis_q     <= tod_reset();
      pend_q    <= '0;
      dirty_q   <= '0;
      te_q      <= 1'b1;
      osc_off_q <= 1'b1;
      sqw_off_q <= 1'b1;
    end else begin
      int_q   <= int_d;
      vis_q   <= vis_d;
      dirty_q <= dirty_d;
      // carry prepared during the 99 slot, applied at rollover
      if (int_q[F_HS] == 8'h99) pend_q <= chain_nxt;
      if (cmd_wr) te_q <= host_wdata[7];
      if (ctl_wr) begin
        osc_off_q <= host_wdata[7];
        sqw_off_q <= host_wdata[6];
      end
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (wdec[3]) host_rdata = vis_q[wsel];
    if (host_addr == A_MON) host_rdata = {osc_off_q, sqw_off_q, 1'b0, vis_q[F_MON][4:0]};
    if (host_addr == A_CMD) host_rdata = {te_q, 7'b0};
  end
endmodule

// File: rtl/rtc_dbl_clock_chk.sv
module rtc_dbl_clock_chk (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_run,
  input logic          hs_roll,
  input logic          te_q,
  input logic          osc_off_q,
  input logic          host_wr,
  input logic [3:0]    host_addr,
  input logic [7:0]    host_rdata,
  input logic          sqw_wave,
  input rtc_pkg::tod_t int_q,
  input rtc_pkg::tod_t vis_q,
  input logic          sec_wrap,
  input logic          min_wrap,
  input logic          day_wrap,
  input logic          mon_wrap,
  input logic          yr_wrap
);
  // R2
  hs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_roll && !host_wr) |=> (int_q[0] == 8'h00));
  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_run && !hs_roll && !host_wr) |=> $stable(int_q[7:1]));
  // R4
  sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_roll && sec_wrap && !host_wr) |=> (int_q[1] == 8'h00));
  // R4
  min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_roll && min_wrap && !host_wr) |=> (int_q[2] == 8'h00));
  // R4
  date_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_roll && day_wrap && !host_wr) |=> (int_q[5] == 8'h01));
  // R4
  mon_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_roll && mon_wrap && !host_wr) |=> (int_q[6] == 8'h01));
  // R4
  yr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_roll && yr_wrap && !host_wr) |=> (int_q[7] == 8'h00));
  // R5
  refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (te_q && tick_run && !host_wr) |=> (vis_q == int_q));
  // R6
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!te_q && !host_wr) |=> $stable(vis_q));
  // R6
  hidden_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!te_q && tick_run && !host_wr) |=> (int_q[0] != $past(int_q[0])));
  // R10
  osc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off_q && !host_wr) |=> $stable(int_q));
  // R11
  wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off_q |=> $stable(sqw_wave));
  // R12
  sec_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 4'h1) |-> !host_rdata[7]);
  // R12
  cmd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 4'hB) |-> (host_rdata[6:0] == 7'b0));
endmodule

bind rtc_dbl_clock rtc_dbl_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_run(tick_run), .hs_roll(hs_roll),
  .te_q(te_q), .osc_off_q(osc_off_q), .host_wr(host_wr),
  .host_addr(host_addr), .host_rdata(host_rdata), .sqw_wave(sqw_wave),
  .int_q(int_q), .vis_q(vis_q), .sec_wrap(sec_wrap), .min_wrap(min_wrap),
  .day_wrap(day_wrap), .mon_wrap(mon_wrap), .yr_wrap(yr_wrap)
);

// File: tb/sim_rtc_dbl_clock.sv
`timescale 1ns/1ps
module sim_rtc_dbl_clock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100hz = 1'b0;
  logic       host_wr = 1'b0;
  logic [3:0] host_addr = 4'h0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       sqw_wave, sqw_drive;

  int n_chk = 0;
  int n_fail = 0;
  bit timed_out = 1'b0;

  always #2 clk = ~clk;

  rtc_dbl_clock #(.SQW_HALF(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sqw_wave(sqw_wave), .sqw_drive(sqw_drive)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
    @(negedge clk);
    host_addr = a;
    #1;
    chk(req, host_rdata, exp);
  endtask

  task automatic tick();
    @(negedge clk); tick_100hz = 1'b1;
    @(negedge clk); tick_100hz = 1'b0;
  endtask

  // hr 23:59:59.98 in the current mode's given encoding, then two ticks
  task automatic end_of_day(logic [7:0] hr);
    wr(4'h4, hr); wr(4'h2, 8'h59); wr(4'h1, 8'h59); wr(4'h0, 8'h98);
    tick(); tick();
  endtask

  task automatic t_reset();
    rd_chk("R1 hs", 4'h0, 8'h00);
    rd_chk("R1 hr", 4'h4, 8'h00);
    rd_chk("R1 dow", 4'h6, 8'h01);
    rd_chk("R1 date", 4'h8, 8'h01);
    rd_chk("R1 mon", 4'h9, 8'hC1);
    rd_chk("R1 yr", 4'hA, 8'h00);
    rd_chk("R1 cmd", 4'hB, 8'h80);
    chk("R1 drive", {7'b0, sqw_drive}, 8'h00);
  endtask

  task automatic t_osc_stop();
    tick(); tick(); tick();
    rd_chk("R10 no count", 4'h0, 8'h00);
    wr(4'h1, 8'h12);
    rd_chk("R10 write applies", 4'h1, 8'h12);
    wr(4'h1, 8'h00);
  endtask

  task automatic t_run();
    wr(4'h9, 8'h01);
    for (int i = 0; i < 5; i++) tick();
    rd_chk("R2 five ticks", 4'h0, 8'h05);
    wr(4'h0, 8'h97);
    tick(); tick();
    rd_chk("R2 reach 99", 4'h0, 8'h99);
    rd_chk("R3 sec not yet", 4'h1, 8'h00);
    tick();
    rd_chk("R2 wrap", 4'h0, 8'h00);
    rd_chk("R3 sec carry", 4'h1, 8'h01);
  endtask

  task automatic t_calendar();
    wr(4'hA, 8'h99); wr(4'h9, 8'h12); wr(4'h8, 8'h31); wr(4'h6, 8'h07);
    wr(4'h4, 8'h23); wr(4'h2, 8'h59); wr(4'h1, 8'h59); wr(4'h0, 8'h98);
    tick();
    rd_chk("R3 sec at 99", 4'h1, 8'h59);
    rd_chk("R3 yr at 99", 4'hA, 8'h99);
    tick();
    rd_chk("R4 sec", 4'h1, 8'h00);
    rd_chk("R4 min", 4'h2, 8'h00);
    rd_chk("R4 hr", 4'h4, 8'h00);
    rd_chk("R4 dow", 4'h6, 8'h01);
    rd_chk("R4 date", 4'h8, 8'h01);
    rd_chk("R4 mon", 4'h9, 8'h01);
    rd_chk("R4 yr", 4'hA, 8'h00);
    // leap February
    wr(4'hA, 8'h04); wr(4'h9, 8'h02); wr(4'h8, 8'h28); wr(4'h6, 8'h03);
    end_of_day(8'h23);
    rd_chk("R4 leap 29", 4'h8, 8'h29);
    rd_chk("R4 leap mon", 4'h9, 8'h02);
    rd_chk("R4 dow step", 4'h6, 8'h04);
    end_of_day(8'h23);
    rd_chk("R4 leap end", 4'h8, 8'h01);
    rd_chk("R4 leap mar", 4'h9, 8'h03);
    // ordinary February
    wr(4'hA, 8'h05); wr(4'h9, 8'h02); wr(4'h8, 8'h28);
    end_of_day(8'h23);
    rd_chk("R4 feb28 end", 4'h8, 8'h01);
    rd_chk("R4 feb28 mar", 4'h9, 8'h03);
    // 30-day month
    wr(4'h9, 8'h04); wr(4'h8, 8'h30);
    end_of_day(8'h23);
    rd_chk("R4 apr end", 4'h8, 8'h01);
    rd_chk("R4 may", 4'h9, 8'h05);
  endtask

  task automatic t_twelve();
    wr(4'h9, 8'h01); wr(4'h8, 8'h10);
    wr(4'h4, 8'h11);
    wr(4'h4, 8'h40);
    rd_chk("R9 to 12h", 4'h4, 8'h51);
    wr(4'h2, 8'h59); wr(4'h1, 8'h59); wr(4'h0, 8'h98);
    tick(); tick();
    rd_chk("R8 noon", 4'h4, 8'h72);
    rd_chk("R8 no date", 4'h8, 8'h10);
    end_of_day(8'h71);
    rd_chk("R8 midnight", 4'h4, 8'h52);
    rd_chk("R8 date step", 4'h8, 8'h11);
    wr(4'h4, 8'h71);
    wr(4'h4, 8'h00);
    rd_chk("R9 to 24h", 4'h4, 8'h23);
  endtask

  task automatic t_freeze();
    wr(4'h0, 8'h10);
    rd_chk("R5 write both", 4'h0, 8'h10);
    tick();
    rd_chk("R5 refresh", 4'h0, 8'h11);
    wr(4'hB, 8'h00);
    rd_chk("R6 cmd", 4'hB, 8'h00);
    for (int i = 0; i < 5; i++) tick();
    rd_chk("R6 held", 4'h0, 8'h11);
    wr(4'hB, 8'h80);
    rd_chk("R6 no loss", 4'h0, 8'h16);
  endtask

  task automatic t_frozen_write();
    wr(4'hB, 8'h00);
    wr(4'h2, 8'h42);
    rd_chk("R7 readback", 4'h2, 8'h42);
    tick(); tick(); tick();
    wr(4'hB, 8'h80);
    rd_chk("R7 adopted", 4'h2, 8'h42);
    rd_chk("R7 hs kept", 4'h0, 8'h19);
    tick();
    rd_chk("R7 counts on", 4'h0, 8'h20);
    rd_chk("R7 min stays", 4'h2, 8'h42);
  endtask

  task automatic t_unused();
    wr(4'h1, 8'hA5);
    rd_chk("R12 sec", 4'h1, 8'h25);
    wr(4'h6, 8'hF3);
    rd_chk("R12 dow", 4'h6, 8'h03);
    wr(4'h8, 8'hD5);
    rd_chk("R12 date", 4'h8, 8'h15);
    wr(4'h9, 8'h21);
    rd_chk("R12 mon", 4'h9, 8'h01);
    wr(4'h3, 8'h5A);
    rd_chk("R12 idx3", 4'h3, 8'h00);
    wr(4'hB, 8'hFF);
    rd_chk("R12 cmd", 4'hB, 8'h80);
    rd_chk("R12 idxC", 4'hC, 8'h00);
  endtask

  task automatic count_toggles(int cycles, output int n);
    logic prev;
    n = 0;
    @(negedge clk);
    prev = sqw_wave;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sqw_wave != prev) n++;
      prev = sqw_wave;
    end
  endtask

  task automatic t_sqw();
    int n;
    wr(4'h9, 8'h01);
    chk("R11 drive on", {7'b0, sqw_drive}, 8'h01);
    count_toggles(32, n);
    chk("R11 toggles", 8'(n), 8'd8);
    wr(4'h9, 8'h81);
    count_toggles(20, n);
    chk("R11 hold stopped", 8'(n), 8'd0);
    wr(4'h9, 8'h41);
    chk("R11 released", {7'b0, sqw_drive}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_osc_stop();
        t_run();
        t_calendar();
        t_twelve();
        t_freeze();
        t_frozen_write();
        t_unused();
        t_sqw();
      end
      begin
        #400000;
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule